// File: doc/BRIEF.md
# Per-Bank Adaptive DRAM Timing Tuner

This block keeps a live set of three DRAM timing values (row precharge time tRP, activate-to-column delay tRCD and CAS latency tCL) for every bank of a rank. The values are moved by a closed loop that is driven by the error reports from the SEC-DED checker, which guards each 64-bit word with 8 check bits. On every epoch tick, a bank that saw no corrected errors steps one cycle closer to its failure edge. A bank that reached the error threshold steps back by two cycles. An uncorrectable error sends the bank straight back to its boot-time nominal values and keeps it parked there for a programmable number of epochs.

The command scheduler queries the tuner through a combinational lookup port that takes a bank index and a precision flag. Approximate requests get the bank's tuned values. Precise requests always get the nominal set, so that precise traffic never runs on shaved margins.

Each bank runs a two-state machine. In `ST_TUNE` the bank adapts at every tick. In `ST_HOLD` it is locked at nominal after an uncorrectable error. An uncorrectable error takes the bank from `ST_TUNE` to `ST_HOLD`, and it also re-arms the lock when the bank is already in `ST_HOLD`. When the lock count runs out on a tick, the bank goes from `ST_HOLD` back to `ST_TUNE`. Reset or `restore` puts every bank into `ST_TUNE` with nominal values.

Top module: `bank_timing_tuner`

## Requirements
- R1: After reset, and in the cycle after `restore` is sampled high, every bank's tuned values equal the nominal inputs, its error count is zero and it is in `ST_TUNE`. `restore` has priority over all other events.
- R2: When `lk_precise` is 1, the lookup outputs equal `nom_trp`, `nom_trcd` and `nom_tcl` for any bank and any tuning state.
- R3: On an epoch tick, a bank in `ST_TUNE` whose error count is zero lowers each of its three values by exactly 1.
- R4: A tightening step never takes a value below its floor input. A value already at or below its floor is left unchanged.
- R5: On an epoch tick, a bank in `ST_TUNE` whose error count is at or above `err_thresh` (and nonzero) raises each value by 2, capped at its nominal value.
- R6: On an epoch tick, a bank in `ST_TUNE` whose error count is between 1 and `err_thresh`-1 keeps its values unchanged.
- R7: Each tick clears every bank's error count. A corrected-error event in the same cycle as a tick counts toward the new epoch. The count saturates at its maximum.
- R8: An uncorrectable-error event for a bank sets its values to nominal in the next cycle and enters `ST_HOLD` with `lock_epochs` loaded. A value of 0 is treated as 1. Each tick in `ST_HOLD` leaves the values unchanged. The tick that uses up the count returns the bank to `ST_TUNE` without tightening, and the tick after that tightens again.
- R9: Events addressed to one bank (`ce_bank`, `ue_bank`) leave every other bank's values and count unchanged.
- R10: When `lk_precise` is 0, the lookup outputs show the tuned values held by bank `lk_bank`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restore | input | 1 | Return all banks to nominal |
| nom_trp | input | TW | Nominal precharge time |
| nom_trcd | input | TW | Nominal activate-to-column delay |
| nom_tcl | input | TW | Nominal CAS latency |
| flr_trp | input | TW | Floor for precharge time |
| flr_trcd | input | TW | Floor for activate-to-column delay |
| flr_tcl | input | TW | Floor for CAS latency |
| err_thresh | input | CNT_W | Corrected-error count that triggers relaxing |
| lock_epochs | input | LOCK_W | Epochs a bank stays locked after an uncorrectable error |
| ce_valid | input | 1 | Corrected-error event |
| ce_bank | input | BW | Bank of the corrected error |
| ue_valid | input | 1 | Uncorrectable-error event |
| ue_bank | input | BW | Bank of the uncorrectable error |
| epoch_tick | input | 1 | End of an adaptation epoch |
| lk_bank | input | BW | Lookup bank index |
| lk_precise | input | 1 | Lookup precision flag, 1 = precise |
| lk_trp | output | TW | Looked-up precharge time |
| lk_trcd | output | TW | Looked-up activate-to-column delay |
| lk_tcl | output | TW | Looked-up CAS latency |

## Verification
Lookup results are combinational and due in the same cycle as the lookup inputs. Any effect of an error event, tick or restore becomes visible exactly one rising edge after that event is sampled. The bench drives every input at the falling edge. It advances its reference model at the next rising edge, using the inputs that edge sampled. It then samples the lookup 1 ns after the following falling edge, so each check sits at a point where exactly one edge has passed. Lock-out sequences are checked tick by tick, so an extra or missing lock epoch shows up in the cycle where it occurs.

// File: rtl/bank_tuner_pkg.sv
package bank_tuner_pkg;
    parameter int TW = 5;

    typedef struct packed {
        logic [TW-1:0] trp;
        logic [TW-1:0] trcd;
        logic [TW-1:0] tcl;
    } timing_t;

    typedef enum logic {ST_TUNE, ST_HOLD} slot_st_e;

    function automatic logic [TW-1:0] step_down(input logic [TW-1:0] v,
                                                input logic [TW-1:0] fl);
        return (v > fl) ? v - TW'(1) : v;
    endfunction

    function automatic logic [TW-1:0] step_up(input logic [TW-1:0] v,
                                              input logic [TW-1:0] nom);
        logic [TW:0] w;
        w = {1'b0, v} + (TW+1)'(2);
        return (w > {1'b0, nom}) ? nom : w[TW-1:0];
    endfunction
endpackage

// File: rtl/bank_timing_slot.sv
module bank_timing_slot
    import bank_tuner_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int LOCK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore,
    input  logic              tick,
    input  logic              ce_hit,
    input  logic              ue_hit,
    input  timing_t           nom,
    input  timing_t           flr,
    input  logic [CNT_W-1:0]  err_thresh,
    input  logic [LOCK_W-1:0] lock_epochs,
    output timing_t           cur
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    slot_st_e          st_q, st_n;
    timing_t           t_q, t_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [LOCK_W-1:0] lock_q, lock_n;

    // next-state and next-value logic
    always_comb begin
        st_n   = st_q;
        t_n    = t_q;
        cnt_n  = cnt_q;
        lock_n = lock_q;
        if (restore) begin
            st_n   = ST_TUNE;
            t_n    = nom;
            cnt_n  = '0;
            lock_n = '0;
        end else if (ue_hit) begin
            st_n   = ST_HOLD;
            t_n    = nom;
            cnt_n  = '0;
            lock_n = lock_epochs;
        end else if (tick) begin
            cnt_n = ce_hit ? CNT_W'(1) : '0;
            unique case (st_q)
                ST_TUNE: begin
                    if (cnt_q == '0) begin
                        t_n.trp  = step_down(t_q.trp,  flr.trp);
                        t_n.trcd = step_down(t_q.trcd, flr.trcd);
                        t_n.tcl  = step_down(t_q.tcl,  flr.tcl);
                    end else if (cnt_q >= err_thresh) begin
                        t_n.trp  = step_up(t_q.trp,  nom.trp);
                        t_n.trcd = step_up(t_q.trcd, nom.trcd);
                        t_n.tcl  = step_up(t_q.tcl,  nom.tcl);
                    end
                end
                ST_HOLD: begin
                    if (lock_q <= LOCK_W'(1)) begin
                        st_n   = ST_TUNE;
                        lock_n = '0;
                    end else begin
                        lock_n = lock_q - LOCK_W'(1);
                    end
                end
            endcase
        end else if (ce_hit && cnt_q != CNT_MAX) begin
            cnt_n = cnt_q + CNT_W'(1);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_TUNE;
        else        st_q <= st_n;
    end

    // timing values, counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q    <= nom;
            cnt_q  <= '0;
            lock_q <= '0;
        end else begin
            t_q    <= t_n;
            cnt_q  <= cnt_n;
            lock_q <= lock_n;
        end
    end

    assign cur = t_q;

    p_ue_to_nominal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_hit && !restore) |=> (st_q == ST_HOLD && t_q == $past(nom)));

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && !restore && !ue_hit) |=> $stable(t_q));

    p_step_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && !ue_hit) |=>
            (({1'b0, t_q.trp} <= {1'b0, $past(t_q.trp)} + (TW+1)'(2)) &&
             ({1'b0, t_q.trp} + (TW+1)'(1) >= {1'b0, $past(t_q.trp)})));

    p_count_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ce_hit) |=> (cnt_q == '0));

    p_restore_tune_r1: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (st_q == ST_TUNE && cnt_q == '0));
endmodule

// File: rtl/timing_lookup_mux.sv
module timing_lookup_mux
    import bank_tuner_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BW = $clog2(NUM_BANKS)
) (
    input  timing_t         bank_t [NUM_BANKS],
    input  timing_t         nom,
    input  logic [BW-1:0]   sel,
    input  logic            precise,
    output timing_t         out
);
    always_comb begin
        out = bank_t[0];
        for (int i = 1; i < NUM_BANKS; i++)
            if (sel == BW'(i)) out = bank_t[i];
        if (precise) out = nom;
    end
endmodule

// File: rtl/bank_timing_tuner.sv
module bank_timing_tuner
    import bank_tuner_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int CNT_W     = 4,
    parameter int LOCK_W    = 3,
    localparam int BW = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore,
    input  logic [TW-1:0]     nom_trp,
    input  logic [TW-1:0]     nom_trcd,
    input  logic [TW-1:0]     nom_tcl,
    input  logic [TW-1:0]     flr_trp,
    input  logic [TW-1:0]     flr_trcd,
    input  logic [TW-1:0]     flr_tcl,
    input  logic [CNT_W-1:0]  err_thresh,
    input  logic [LOCK_W-1:0] lock_epochs,
    input  logic              ce_valid,
    input  logic [BW-1:0]     ce_bank,
    input  logic              ue_valid,
    input  logic [BW-1:0]     ue_bank,
    input  logic              epoch_tick,
    input  logic [BW-1:0]     lk_bank,
    input  logic              lk_precise,
    output logic [TW-1:0]     lk_trp,
    output logic [TW-1:0]     lk_trcd,
    output logic [TW-1:0]     lk_tcl
);
    timing_t nom, flr, sel_t;
    timing_t bank_t [NUM_BANKS];

    assign nom = '{trp: nom_trp, trcd: nom_trcd, tcl: nom_tcl};
    assign flr = '{trp: flr_trp, trcd: flr_trcd, tcl: flr_tcl};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_timing_slot #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .restore     (restore),
            .tick        (epoch_tick),
            .ce_hit      (ce_valid && ce_bank == BW'(b)),
            .ue_hit      (ue_valid && ue_bank == BW'(b)),
            .nom         (nom),
            .flr         (flr),
            .err_thresh  (err_thresh),
            .lock_epochs (lock_epochs),
            .cur         (bank_t[b])
        );
    end

    timing_lookup_mux #(.NUM_BANKS(NUM_BANKS)) u_mux (
        .bank_t  (bank_t),
        .nom     (nom),
        .sel     (lk_bank),
        .precise (lk_precise),
        .out     (sel_t)
    );

    assign lk_trp  = sel_t.trp;
    assign lk_trcd = sel_t.trcd;
    assign lk_tcl  = sel_t.tcl;

    p_precise_nominal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_precise |-> (lk_trp == nom_trp && lk_trcd == nom_trcd && lk_tcl == nom_tcl));

    p_restore_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !lk_precise) |=> (lk_trp == $past(nom_trp) || lk_precise));
endmodule

// File: tb/bank_timing_tuner_tb.sv
`timescale 1ns/1ps
module bank_timing_tuner_tb;
    localparam int NB = 8;
    localparam int TWB = 5;

    logic clk = 0, rst_n = 0, restore = 0;
    logic [TWB-1:0] nom_trp = 14, nom_trcd = 15, nom_tcl = 13;
    logic [TWB-1:0] flr_trp = 9, flr_trcd = 10, flr_tcl = 8;
    logic [3:0] err_thresh = 3;
    logic [2:0] lock_epochs = 2;
    logic ce_valid = 0, ue_valid = 0, epoch_tick = 0, lk_precise = 0;
    logic [2:0] ce_bank = 0, ue_bank = 0, lk_bank = 0;
    logic [TWB-1:0] lk_trp, lk_trcd, lk_tcl;

    int checks = 0, errors = 0;
    int m_p [NB][3];
    int m_cnt [NB], m_lock [NB];
    bit m_hold [NB];

    always #5 clk = ~clk;

    bank_timing_tuner u_dut (
        .clk(clk), .rst_n(rst_n), .restore(restore),
        .nom_trp(nom_trp), .nom_trcd(nom_trcd), .nom_tcl(nom_tcl),
        .flr_trp(flr_trp), .flr_trcd(flr_trcd), .flr_tcl(flr_tcl),
        .err_thresh(err_thresh), .lock_epochs(lock_epochs),
        .ce_valid(ce_valid), .ce_bank(ce_bank),
        .ue_valid(ue_valid), .ue_bank(ue_bank),
        .epoch_tick(epoch_tick), .lk_bank(lk_bank), .lk_precise(lk_precise),
        .lk_trp(lk_trp), .lk_trcd(lk_trcd), .lk_tcl(lk_tcl)
    );

    function automatic int nomv(int k);
        return (k == 0) ? int'(nom_trp) : (k == 1) ? int'(nom_trcd) : int'(nom_tcl);
    endfunction
    function automatic int flrv(int k);
        return (k == 0) ? int'(flr_trp) : (k == 1) ? int'(flr_trcd) : int'(flr_tcl);
    endfunction

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            for (int k = 0; k < 3; k++) m_p[b][k] = nomv(k);
            m_cnt[b] = 0; m_lock[b] = 0; m_hold[b] = 0;
        end
    endtask

    task automatic model_edge(bit rs, bit cv, int cb, bit uv, int ub, bit tk);
        if (rs) begin model_reset(); return; end
        for (int b = 0; b < NB; b++) begin
            bit ch = cv && cb == b;
            if (uv && ub == b) begin
                for (int k = 0; k < 3; k++) m_p[b][k] = nomv(k);
                m_hold[b] = 1; m_lock[b] = int'(lock_epochs); m_cnt[b] = 0;
            end else if (tk) begin
                if (m_hold[b]) begin
                    if (m_lock[b] <= 1) begin m_hold[b] = 0; m_lock[b] = 0; end
                    else m_lock[b]--;
                end else if (m_cnt[b] == 0) begin
                    for (int k = 0; k < 3; k++)
                        if (m_p[b][k] > flrv(k)) m_p[b][k]--;
                end else if (m_cnt[b] >= int'(err_thresh)) begin
                    for (int k = 0; k < 3; k++)
                        m_p[b][k] = (m_p[b][k] + 2 > nomv(k)) ? nomv(k) : m_p[b][k] + 2;
                end
                m_cnt[b] = ch ? 1 : 0;
            end else if (ch && m_cnt[b] < 15) m_cnt[b]++;
        end
    endtask

    // drive at falling edge, clock one rising edge, return at next falling edge
    task automatic step(bit rs, bit cv, int cb, bit uv, int ub, bit tk);
        restore = rs; ce_valid = cv; ce_bank = 3'(cb);
        ue_valid = uv; ue_bank = 3'(ub); epoch_tick = tk;
        @(posedge clk);
        model_edge(rs, cv, cb, uv, ub, tk);
        @(negedge clk);
        restore = 0; ce_valid = 0; ue_valid = 0; epoch_tick = 0;
    endtask

    task automatic look(string tag, int b, bit pr);
        int e0, e1, e2;
        lk_bank = 3'(b); lk_precise = pr;
        #1;
        e0 = pr ? nomv(0) : m_p[b][0];
        e1 = pr ? nomv(1) : m_p[b][1];
        e2 = pr ? nomv(2) : m_p[b][2];
        checks++;
        if (int'(lk_trp) != e0 || int'(lk_trcd) != e1 || int'(lk_tcl) != e2) begin
            errors++;
            $display("FAIL %s bank %0d precise %0d: got %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, b, pr, lk_trp, lk_trcd, lk_tcl, e0, e1, e2);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1);
    endtask

    bit done = 0;
    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd11));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        for (int b = 0; b < NB; b++) look("R1", b, 0);

        ticks(1);
        look("R3", 0, 0); look("R3", 7, 0);
        look("R2", 7, 1);
        ticks(6);
        look("R4", 1, 0); look("R4", 6, 0);

        // bank 2 relaxes after threshold errors
        repeat (3) step(0, 1, 2, 0, 0, 0);
        ticks(1);
        look("R5", 2, 0); look("R9", 3, 0);
        ticks(1);
        look("R3", 2, 0);
        // one error below threshold: no change
        step(0, 1, 2, 0, 0, 0);
        ticks(1);
        look("R6", 2, 0);

        // corrected error during tick counts toward next epoch
        step(0, 1, 4, 0, 0, 1);
        look("R7", 4, 0);
        repeat (2) step(0, 1, 4, 0, 0, 0);
        ticks(1);
        look("R7", 4, 0);

        // uncorrectable error and lockout
        step(0, 0, 0, 1, 5, 0);
        look("R8", 5, 0); look("R9", 6, 0);
        ticks(1); look("R8", 5, 0);
        ticks(1); look("R8", 5, 0);
        ticks(1); look("R8", 5, 0);
        look("R2", 5, 1);

        // lock of zero behaves as one epoch
        lock_epochs = 0;
        step(0, 0, 0, 1, 1, 0);
        ticks(1); look("R8", 1, 0);
        ticks(1); look("R8", 1, 0);
        lock_epochs = 2;

        step(1, 1, 3, 1, 3, 1);
        for (int b = 0; b < NB; b++) look("R1", b, 0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            bit cv = ($urandom % 3) == 0;
            bit uv = ($urandom % 80) == 0;
            bit tk = ($urandom % 6) == 0;
            bit rs = ($urandom % 500) == 0;
            step(rs, cv, int'($urandom % NB), uv, int'($urandom % NB), tk);
            look("R10", int'($urandom % NB), ($urandom % 4) == 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule